// File: doc/BRIEF.md
# Scaled-Index Byte Store Address Unit

This unit carries out a single-byte store whose address is built from a base register and a scaled index register. For each accepted operation it multiplies the index value by a power of two between 2 and 16, adds a base term, and then issues a one-byte write request to memory carrying the least significant byte of the source value. The base term comes from the base register contents unless the base register selector is zero. A selector of zero stands for the constant zero.

The operand values are supplied by the surrounding pipeline together with an issue strobe. The unit holds one store at a time. It raises a busy flag while its memory request waits for acknowledgement and ignores new issues during that time. It writes back no register and changes no status. Translation, alignment checks and the memory itself live outside the block.

Top module: `sbx_store_unit`

## Requirements
- R1: One cycle after an accepted issue, `mem_addr` equals (`index_val` << (`scale_sel`+1)) + base term, computed modulo 2^XLEN, so a sum that overflows wraps around.
- R2: When `base_sel` is 0, the base term is zero whatever value is on `base_val`.
- R3: When `base_sel` is not 0, the base term is `base_val`, including the case where `base_val` itself is zero.
- R4: `mem_wdata` equals bits [7:0] of `src_val`. Bits [XLEN-1:8] of `src_val` have no effect on the request.
- R5: While `mem_req` is high, `mem_size` shows the byte code 2'b00. The code table is 00 byte, 01 halfword, 10 word, 11 doubleword.
- R6: `scale_sel` values 0, 1, 2 and 3 scale the index by 2, 4, 8 and 16. Index bits shifted above bit XLEN-1 are discarded.
- R7: An issue is accepted when `issue_vld` is high and `busy` is low at a clock edge. `mem_req` rises in the following cycle, and `mem_req`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is sampled high.
- R8: `mem_req` and `busy` go low in the cycle after `mem_req` and `mem_ack` are both high. `busy` is high whenever `mem_req` is high.
- R9: An issue made while `busy` is high is ignored. The outstanding request keeps its address and data, and no further request follows the acknowledgement.
- R10: After a synchronous reset, `mem_req` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Operation issue strobe |
| base_sel | input | SEL_W | Base register selector (0 means constant zero) |
| base_val | input | XLEN | Base register contents |
| index_val | input | XLEN | Index register contents |
| scale_sel | input | SH_W | Shift field: index shifted left by scale_sel+1 |
| src_val | input | XLEN | Source register value; low byte is stored |
| busy | output | 1 | A store request is outstanding |
| mem_req | output | 1 | Memory write request valid |
| mem_addr | output | XLEN | Byte address of the write |
| mem_wdata | output | 8 | Byte to write |
| mem_size | output | 2 | Access size code (00 = byte) |
| mem_ack | input | 1 | Memory accepts the request |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 5-bit selector and a 2-bit shift field. With these values all four scale factors can be reached, index bits can be pushed past bit 63 at the largest shift, and a base near the top of the address space makes the final addition wrap. Acknowledgement delays from zero to several cycles test both the back-to-back case and a request that has to wait. The longer delays give time to issue operations while the unit is busy.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } size_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sbx_index_scaler.sv
module sbx_index_scaler #(
  parameter int XLEN = 64,
  parameter int SH_W = 2
) (
  input  logic [XLEN-1:0] index_i,
  input  logic [SH_W-1:0] sel_i,
  output logic [XLEN-1:0] scaled_o
);
  localparam int NSH = 1 << SH_W;

  logic [XLEN-1:0] cand [NSH];

  // One candidate per shift amount; the minimum shift is one position.
  for (genvar k = 0; k < NSH; k++) begin : g_shift
    assign cand[k] = index_i << (k + 1);
  end

  assign scaled_o = cand[sel_i];
endmodule

// File: rtl/sbx_ea_adder.sv
module sbx_ea_adder #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  scaled_i,
  output logic [XLEN-1:0]  ea_o
);
  logic [XLEN-1:0] base_term;

  // Selector zero means "no base", independent of the register contents.
  assign base_term = (sel_i == '0) ? '0 : base_i;
  assign ea_o      = scaled_i + base_term;
endmodule

// File: rtl/sbx_req_reg.sv
module sbx_req_reg #(
  parameter int XLEN   = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [XLEN-1:0]   addr_o,
  output logic [BYTE_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
    end else if (load_i) begin
      req_o <= 1'b1;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i && !load_i) |=> !req_o);
endmodule

// File: rtl/sbx_store_unit.sv
module sbx_store_unit #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 5,
  parameter int SH_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_vld,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [SH_W-1:0]  scale_sel,
  input  logic [XLEN-1:0]  src_val,
  output logic             busy,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [1:0]       mem_size,
  input  logic             mem_ack
);
  import sbx_pkg::*;

  logic            accept;
  logic [XLEN-1:0] scaled_idx;
  logic [XLEN-1:0] ea;
  logic [XLEN-9:0] unused_src_hi;

  assign unused_src_hi = src_val[XLEN-1:BYTE_W];

  sbx_index_scaler #(.XLEN(XLEN), .SH_W(SH_W)) u_scale (
    .index_i (index_val),
    .sel_i   (scale_sel),
    .scaled_o(scaled_idx)
  );

  sbx_ea_adder #(.XLEN(XLEN), .SEL_W(SEL_W)) u_add (
    .sel_i   (base_sel),
    .base_i  (base_val),
    .scaled_i(scaled_idx),
    .ea_o    (ea)
  );

  assign accept = issue_vld && !busy;

  sbx_req_reg #(.XLEN(XLEN), .BYTE_W(BYTE_W)) u_req (
    .clk   (clk),
    .rst   (rst),
    .load_i(accept),
    .addr_i(ea),
    .data_i(src_val[BYTE_W-1:0]),
    .ack_i (mem_ack),
    .req_o (mem_req),
    .addr_o(mem_addr),
    .data_o(mem_wdata)
  );

  assign busy     = mem_req;
  assign mem_size = SZ_BYTE;

  p_launch_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_req);

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_addr == $past(ea)));

  p_zero_base_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && base_sel == '0) |=> (mem_addr == $past(scaled_idx)));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && issue_vld && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/sbx_store_unit_test.sv
module sbx_store_unit_test;
  localparam int XLEN = 64;
  localparam int SEL_W = 5;
  localparam int SH_W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst = 1'b1;
  logic             issue_vld = 1'b0;
  logic [SEL_W-1:0] base_sel = '0;
  logic [XLEN-1:0]  base_val = '0;
  logic [XLEN-1:0]  index_val = '0;
  logic [SH_W-1:0]  scale_sel = '0;
  logic [XLEN-1:0]  src_val = '0;
  logic             busy, mem_req;
  logic [XLEN-1:0]  mem_addr;
  logic [7:0]       mem_wdata;
  logic [1:0]       mem_size;
  logic             mem_ack = 1'b0;

  sbx_store_unit #(.XLEN(XLEN), .SEL_W(SEL_W), .SH_W(SH_W)) uut (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .base_sel(base_sel),
    .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
    .src_val(src_val), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_ack(mem_ack)
  );

  typedef struct packed {
    logic [XLEN-1:0] a;
    logic [7:0]      d;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  bit ack_given = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [XLEN-1:0] held_a;
  logic [7:0] held_d;

  task automatic chk(input bit ok, input string tag,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard: runs away from the active edge.
  always @(negedge clk) begin
    if (mon_on) begin
      mem_ack = 1'b0;
      if (ack_given) begin
        chk(!mem_req, "R8 request drops after ack", {63'd0, mem_req}, 0);
        chk(!busy, "R8 busy clears after ack", {63'd0, busy}, 0);
        ack_given = 1'b0;
      end else if (mem_req) begin
        chk(busy, "R8 busy while request", {63'd0, busy}, 1);
        chk(mem_size == 2'b00, "R5 byte size code", {62'd0, mem_size}, 0);
        if (wait_cnt == 0) begin
          held_a = mem_addr;
          held_d = mem_wdata;
        end else begin
          chk(mem_addr == held_a, "R7 address held", mem_addr, held_a);
          chk(mem_wdata == held_d, "R7 data held", {56'd0, mem_wdata}, {56'd0, held_d});
        end
        if (wait_cnt >= ack_delay) begin
          if (q.size() == 0) begin
            chk(1'b0, "R9 spurious request", mem_addr, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(mem_addr == e.a, "R1 effective address", mem_addr, e.a);
            chk(mem_wdata == e.d, "R4 low byte stored", {56'd0, mem_wdata}, {56'd0, e.d});
          end
          mem_ack = 1'b1;
          ack_given = 1'b1;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Driver: called at a negedge; expected value follows the requirement formula.
  task automatic issue(input logic [SEL_W-1:0] s, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] x, input logic [SH_W-1:0] sh,
                       input logic [XLEN-1:0] r);
    exp_t e;
    logic [XLEN-1:0] sc;
    while (busy) @(negedge clk);
    sc = x << (32'(sh) + 1);
    e.a = sc + ((s == '0) ? '0 : b);
    e.d = r[7:0];
    q.push_back(e);
    base_sel = s; base_val = b; index_val = x; scale_sel = sh; src_val = r;
    issue_vld = 1'b1;
    @(negedge clk);
    issue_vld = 1'b0;
    chk(mem_req, "R7 request one cycle after issue", {63'd0, mem_req}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req, "R10 no request after reset", {63'd0, mem_req}, 0);
    chk(!busy, "R10 not busy after reset", {63'd0, busy}, 0);
    mon_on = 1'b1;

    // R1 basic, R4 upper source bits ignored
    ack_delay = 0;
    issue(5'd3, 64'h1000, 64'h10, 2'd0, 64'hDEAD_BEEF_CAFE_F00D);
    issue(5'd3, 64'h1000, 64'h10, 2'd0, 64'h1234_5678_9ABC_DE0D);
    // R6 scale factors 4, 8, 16
    ack_delay = 1;
    issue(5'd7, 64'h2000, 64'h3, 2'd1, 64'h11);
    issue(5'd7, 64'h2000, 64'h3, 2'd2, 64'h22);
    issue(5'd7, 64'h2000, 64'h3, 2'd3, 64'h33);
    // R2 selector zero ignores a nonzero base value
    issue(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 2'd0, 64'h44);
    // R3 nonzero selector with zero base value
    issue(5'd5, 64'h0, 64'h40, 2'd2, 64'h55);
    // R6 bits shifted past the top are discarded
    issue(5'd1, 64'h5, 64'hF000_0000_0000_0001, 2'd3, 64'h66);
    // R1 wraparound of the final sum
    ack_delay = 2;
    issue(5'd31, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 2'd0, 64'h77);

    // R9 issues while busy are ignored
    ack_delay = 4;
    issue(5'd2, 64'h8000, 64'h8, 2'd1, 64'hA5);
    base_sel = 5'd9; base_val = 64'h1; index_val = 64'h1; src_val = 64'h5A;
    issue_vld = 1'b1;
    repeat (2) @(negedge clk);
    issue_vld = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req, "R9 no request from ignored issue", {63'd0, mem_req}, 0);
    end

    // Back-to-back after a long wait
    ack_delay = 0;
    issue(5'd4, 64'h100, 64'h1, 2'd3, 64'hFF);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 every issue served", 64'(q.size()), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule